// File: doc/BRIEF.md
# Leading and Trailing Bit Counter

This unit takes one instruction word and one 64-bit operand. It returns the length of the run of equal bits at one end of the operand. The run can start at the most significant end (leading) or at the least significant end (trailing). The bits counted can be ones or zeros. The count covers either the whole 64-bit value (doubleword mode) or only its low 32 bits (word mode).

An internal decoder reads the minor opcode field of the instruction and turns it into a three-bit operation select. Only the eight counting encodings are accepted. Any other instruction word produces no result.

The operand is conditioned first. For ones-counts it is inverted. For leading counts it is bit-reversed. In word mode it is padded with ones above bit 31. A single grouped trailing-zero counter then finds the answer. The count is zero-extended into a 64-bit result. The result and the destination register index are registered, and they appear one clock after the input.

Top module: `bit_count_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0, `out_data` is 0 and `out_rd` is 0.
- R2: `out_valid` is 1 exactly one clock after a cycle with `in_valid` high and a legal instruction. It is 0 after any cycle with `in_valid` low.
- R3: An instruction is legal only when bits 31:15 are all zero and bits 14:10 lie in the range 00100 to 01011. An illegal instruction with `in_valid` high gives `out_valid` 0 on the next cycle.
- R4: `out_rd` carries bits 4:0 of the accepted instruction. Bits 9:5 (the source index) do not affect the result.
- R5: The value of bits 14:10 minus 00100 is the operation select. Bit 0 of the select chooses zeros (1) or ones (0). Bit 1 chooses trailing (1) or leading (0). Bit 2 chooses doubleword (1) or word (0).
- R6: Word leading-zero count (00101) looks at operand bits 31:0 only. It returns 0 to 32, and 32 when the low word is zero.
- R7: Word leading-ones count (00100) inverts the operand, keeps the low 32 bits, and counts leading zeros of that word. It returns 32 when the low word is all ones.
- R8: Word trailing-zero count (00111) ignores bits 63:32. It returns 32 when the low word is zero.
- R9: Word trailing-ones count (00110) ignores bits 63:32. It returns 32 when the low word is all ones.
- R10: The doubleword counts (01000 to 01011) look at all 64 bits. A zero operand gives 64 for the zero counts, and an all-ones operand gives 64 for the ones counts.
- R11: The count is zero-extended: `out_data[63:7]` is always 0.
- R12: After a cycle with no accepted input, `out_data` and `out_rd` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_insn | input | 32 | Instruction word |
| in_src | input | 64 | Operand value |
| out_valid | output | 1 | Result strobe, one cycle after input |
| out_data | output | 64 | Zero-extended count |
| out_rd | output | 5 | Destination register index |

## Verification
The assertions assume that `in_valid`, `in_insn` and `in_src` are settled at every rising edge. They also assume that bit 13 of an accepted instruction marks doubleword mode, which holds for every legal encoding.

The stimulus changes inputs only on the falling edge. It sends legal instructions only from the eight listed encodings. Illegal words are used only to check that they are rejected, and those cases are expected to produce no result.

Operands include zero, all-ones, every single-bit value, a value with only the low word set, a value with only the high word set, and random values. Idle cycles carry random instruction and operand values, to show that unaccepted input changes nothing.

// File: rtl/ltbc_pkg.sv
package ltbc_pkg;
  typedef struct packed {
    logic dword;  // 1: 64-bit operand, 0: low 32 bits
    logic trail;  // 1: count from bit 0 upward
    logic zeros;  // 1: count zeros, 0: count ones
  } cnt_op_t;

  localparam logic [4:0] MINOR_FIRST = 5'b00100;
  localparam logic [4:0] MINOR_LAST  = 5'b01011;
endpackage

// File: rtl/ltbc_decode.sv
module ltbc_decode
  import ltbc_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output cnt_op_t           op,
  output logic              legal,
  output logic [4:0]        rd
);
  logic [4:0] minor;
  logic [4:0] rel;

  always_comb begin
    minor = insn[14:10];
    rel   = minor - MINOR_FIRST;
    legal = (insn[INSN_W-1:15] == '0) && (minor >= MINOR_FIRST) && (minor <= MINOR_LAST);
    op    = cnt_op_t'(rel[2:0]);
    rd    = insn[4:0];
  end
endmodule

// File: rtl/ltbc_prep.sv
module ltbc_prep
  import ltbc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  cnt_op_t           op,
  output logic [DATA_W-1:0] vec
);
  localparam int PAD_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] pol;
  logic [DATA_W-1:0] rev_d;
  logic [WORD_W-1:0] rev_w;

  assign pol = op.zeros ? src : ~src;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_d
    assign rev_d[i] = pol[DATA_W-1-i];
  end
  for (genvar i = 0; i < WORD_W; i++) begin : g_rev_w
    assign rev_w[i] = pol[WORD_W-1-i];
  end

  always_comb begin
    if (op.dword) begin
      vec = op.trail ? pol : rev_d;
    end else begin
      vec = {{PAD_W{1'b1}}, (op.trail ? pol[WORD_W-1:0] : rev_w)};
    end
  end
endmodule

// File: rtl/ltbc_tzcnt.sv
module ltbc_tzcnt #(
  parameter int W  = 64,
  parameter int GW = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  x,
  output logic [CW-1:0] cnt
);
  localparam int NG  = W / GW;
  localparam int GCW = (GW > 1) ? $clog2(GW) : 1;

  function automatic logic [GCW-1:0] grp_tz(input logic [GW-1:0] g);
    logic [GCW-1:0] r;
    r = '0;
    for (int b = GW - 1; b >= 0; b--) begin
      if (g[b]) r = GCW'(b);
    end
    return r;
  endfunction

  logic [NG-1:0]           gnz;
  logic [NG-1:0][GCW-1:0]  gtz;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign gnz[g] = |x[g*GW +: GW];
    assign gtz[g] = grp_tz(x[g*GW +: GW]);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    cnt   = CW'(W);
    for (int g = 0; g < NG; g++) begin
      if (!found && gnz[g]) begin
        cnt   = CW'(g * GW) + CW'(gtz[g]);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit
  import ltbc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int GRP_W  = 8,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_src,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [4:0]        out_rd
);
  localparam int CW = $clog2(DATA_W + 1);

  cnt_op_t           op;
  logic              legal;
  logic [4:0]        rd;
  logic [DATA_W-1:0] vec;
  logic [CW-1:0]     cnt;

  ltbc_decode #(.INSN_W(INSN_W)) u_dec (
    .insn(in_insn), .op(op), .legal(legal), .rd(rd)
  );

  ltbc_prep #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_prep (
    .src(in_src), .op(op), .vec(vec)
  );

  ltbc_tzcnt #(.W(DATA_W), .GW(GRP_W)) u_cnt (
    .x(vec), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_rd    <= '0;
    end else begin
      out_valid <= in_valid && legal;
      if (in_valid && legal) begin
        out_data <= {{(DATA_W-CW){1'b0}}, cnt};
        out_rd   <= rd;
      end
    end
  end
endmodule

// File: rtl/ltbc_checker.sv
module ltbc_checker #(
  parameter int DATA_W = 64,
  parameter int INSN_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [INSN_W-1:0] in_insn,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [4:0]        out_rd
);
  localparam int CW = $clog2(DATA_W + 1);

  // R1
  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !out_valid && out_data == '0);

  // R2
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6
  p_word_cap_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_insn[13]) |=> (!out_valid || out_data <= DATA_W'(32)));

  // R10
  p_dword_cap_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data <= DATA_W'(DATA_W));

  // R11
  p_zero_ext_r11: assert property (@(posedge clk) disable iff (rst)
    out_data[DATA_W-1:CW] == '0);

  // R12
  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data) && $stable(out_rd));
endmodule

bind bit_count_unit ltbc_checker #(.DATA_W(DATA_W), .INSN_W(INSN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
  .out_valid(out_valid), .out_data(out_data), .out_rd(out_rd)
);

// File: tb/tb_bit_count_unit.sv
module tb_bit_count_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_insn = '0;
  logic [63:0] in_src = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [4:0]  out_rd;

  always #4 clk = ~clk;

  bit_count_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn), .in_src(in_src),
    .out_valid(out_valid), .out_data(out_data), .out_rd(out_rd)
  );

  typedef struct {
    bit          v;
    logic [63:0] d;
    logic [4:0]  rd;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [63:0] last_d = '0;
  logic [4:0]  last_rd = '0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_cnt(logic [2:0] sel, logic [63:0] s);
    int n;
    int c;
    bit stop;
    logic [63:0] v;
    n = sel[2] ? 64 : 32;
    v = sel[0] ? s : ~s;
    c = 0;
    stop = 0;
    for (int i = 0; i < n; i++) begin
      int k;
      k = sel[1] ? i : (n - 1 - i);
      if (!stop) begin
        if (v[k]) stop = 1;
        else c++;
      end
    end
    return 64'(c);
  endfunction

  function automatic string op_tag(logic [2:0] sel);
    case (sel)
      3'd0: return "R5 R7 CLO.W";
      3'd1: return "R5 R6 CLZ.W";
      3'd2: return "R5 R9 CTO.W";
      3'd3: return "R5 R8 CTZ.W";
      default: return "R5 R10 doubleword";
    endcase
  endfunction

  task automatic drive(bit vld, logic [31:0] insn, logic [63:0] src);
    exp_t e;
    logic [4:0] minor;
    bit legal;
    @(negedge clk);
    in_valid = vld;
    in_insn  = insn;
    in_src   = src;
    minor = insn[14:10];
    legal = (insn[31:15] == 0) && (minor >= 5'd4) && (minor <= 5'd11);
    if (vld && legal) begin
      last_d  = ref_cnt(3'(minor - 5'd4), src);
      last_rd = insn[4:0];
      e.v = 1; e.tag = op_tag(3'(minor - 5'd4));
    end else begin
      e.v = 0; e.tag = vld ? "R3 illegal" : "R2 R12 idle";
    end
    e.d = last_d;
    e.rd = last_rd;
    q.push_back(e);
  endtask

  function automatic logic [31:0] mk(logic [4:0] minor, logic [4:0] rj, logic [4:0] rd);
    return {17'b0, minor, rj, rd};
  endfunction

  task automatic run_op(logic [2:0] sel, logic [63:0] src);
    drive(1, mk(5'd4 + 5'(sel), 5'($urandom), 5'($urandom)), src);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(out_valid == e.v, {e.tag, " valid R2"}, 64'(out_valid), 64'(e.v));
        check(out_data == e.d, e.tag, out_data, e.d);
        check(out_rd == e.rd, {e.tag, " R4 rd"}, 64'(out_rd), 64'(e.rd));
        check(out_data[63:7] == 0, "R11 zero-ext", out_data, e.d);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    check(out_valid == 0 && out_data == 0 && out_rd == 0, "R1 during reset", out_data, 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    check(out_valid == 0 && out_data == 0 && out_rd == 0, "R1 after reset", out_data, 0);

    for (int s = 0; s < 8; s++) begin
      run_op(3'(s), 64'h0);
      run_op(3'(s), '1);
      run_op(3'(s), 64'h0000_0000_FFFF_FFFF);
      run_op(3'(s), 64'hFFFF_FFFF_0000_0000);
      for (int b = 0; b < 64; b++) begin
        run_op(3'(s), 64'h1 << b);
        run_op(3'(s), ~(64'h1 << b));
      end
    end

    // R4: the rj field has no effect on the count
    drive(1, mk(5'd5, 5'd0, 5'd3), 64'h0000_0000_0001_0000);
    drive(1, mk(5'd5, 5'd31, 5'd17), 64'h0000_0000_0001_0000);

    // R3: illegal encodings
    drive(1, mk(5'd3, 5'd1, 5'd2), 64'h1234);
    drive(1, mk(5'd12, 5'd1, 5'd2), 64'h1234);
    drive(1, mk(5'd0, 5'd1, 5'd2), 64'h1234);
    drive(1, mk(5'd5, 5'd1, 5'd2) | 32'h0000_8000, 64'h1234);
    drive(1, mk(5'd9, 5'd1, 5'd2) | 32'h8000_0000, 64'h1234);

    // random mix with idle cycles (R2, R12)
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        drive(0, mk(5'($urandom_range(4, 11)), 5'($urandom), 5'($urandom)), {$urandom, $urandom});
      else
        run_op(3'($urandom), {$urandom, $urandom} >> $urandom_range(0, 63));
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(q.size() == 0, "R2 queue drained", 64'(q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule